// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker sits behind a translation cache and runs when a lookup misses. It takes a 32-bit virtual address, the access type (read or write) and the privilege mode (user or supervisor). It then walks a two-level table held in ordinary memory. The virtual address is split into three fields:

- bits 31:22 select an entry of the directory, which a base register points to;
- bits 21:12 select an entry of the second-level table named by that directory entry;
- bits 11:0 are the page offset, passed through unchanged.

Each entry is 32 bits. Bits 31:12 hold a 4 KB-aligned physical page base and the low bits hold flags. The walker checks the present and permission flags at both levels. On a successful walk it writes back the accessed and dirty flags, but only where they change. It then returns the physical address. On a failed walk it returns a fault report giving the virtual address, the cause, the access type and the mode.

Memory is reached through one word-wide port. A request is held until an acknowledge pulse. Read data is valid in the acknowledge cycle. One walk is in flight at a time.

Top module: `xlat_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req` are 0.
- R2: The first memory access of a walk is a read at `dir_base + 4*vaddr[31:22]`.
- R3: When the directory entry has bit 0 (present) set, the second access is a read at `{dir_entry[31:12],12'h000} + 4*vaddr[21:12]`.
- R4: When both entries are present and no protection rule is broken, the response has `rsp_fault`=0 and `rsp_paddr = {table_entry[31:12], vaddr[11:0]}`.
- R5: A directory entry with bit 0 clear ends the walk after one read. The result is a fault with `rsp_prot`=0 and no memory writes.
- R6: A table entry with bit 0 clear gives a fault with `rsp_prot`=0 after exactly two reads and no writes.
- R7: When both entries are present, the walk faults with `rsp_prot`=1 in either of two cases: a write where bit 1 (read/write) is 0 at either level, or a user access where bit 2 (user/supervisor) is 0 at either level. A non-present entry takes precedence and reports `rsp_prot`=0.
- R8: A fault response returns the request's virtual address on `rsp_vaddr`, its access type on `rsp_write` and its mode on `rsp_user`.
- R9: After a successful walk, bit 5 (accessed) is set in memory in both entries. Bit 6 (dirty) of the table entry is set when the access was a write. No other bit changes.
- R10: An entry is written only when its flag bits actually change. A walk that faults writes nothing. When both entries are written, the directory entry is written first.
- R11: Each accepted request gives exactly one `rsp_valid` pulse of one cycle. `req_ready` is 0 from acceptance until after that pulse.
- R12: While `mem_req` is 1 and `mem_ack` is 0, the memory command (`mem_addr`, `mem_we`, `mem_wdata`) stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_base | input | 32 | Physical address of the directory, sampled when a request is accepted |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | 1 = page fault, 0 = translation good |
| rsp_paddr | output | 32 | Physical address (valid when no fault) |
| rsp_vaddr | output | 32 | Virtual address of the walk |
| rsp_prot | output | 1 | Fault cause: 1 = protection, 0 = not present |
| rsp_write | output | 1 | Access type of the walk |
| rsp_user | output | 1 | Privilege mode of the walk |
| mem_req | output | 1 | Memory command valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Command completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The hardest cases to reach are the write-back path and its counterpart: a walk that must issue two writes, and one that must issue none because accessed and dirty are already set.

Random tables seldom line up those exact flag combinations with the right access type. Directed cases therefore seed entries with accessed clear at both levels, and with both flags already set under a write. The memory model counts reads and writes per walk, which makes a missing or spurious write visible at the port.

The random part draws flags for every entry and inserts acknowledge stalls. This covers fault precedence and stable commands under backpressure.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W  = 32;
    localparam int DIR_W = 10;
    localparam int TBL_W = 10;
    localparam int OFF_W = VA_W - DIR_W - TBL_W;
    localparam int PN_W  = VA_W - OFF_W;

    localparam int F_PRES  = 0;
    localparam int F_RW    = 1;
    localparam int F_US    = 2;
    localparam int F_ACC   = 5;
    localparam int F_DIRTY = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_RD_TBL,
        ST_SET_AD,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef struct packed {
        walk_st_e          st;
        logic [VA_W-1:0]   vaddr;
        logic [VA_W-1:0]   base;
        logic              wr;
        logic              usr;
        logic [VA_W-1:0]   pde;
        logic [VA_W-1:0]   pte;
        logic              pde_pend;
        logic              pte_pend;
        logic              flt_prot;
    } walk_regs_t;
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0]  base_i,
    input  logic [DIR_W-1:0] dir_idx_i,
    input  logic [TBL_W-1:0] tbl_idx_i,
    input  logic [PN_W-1:0]  tbl_pn_i,
    output logic [VA_W-1:0]  dir_addr_o,
    output logic [VA_W-1:0]  tbl_addr_o
);
    localparam int DPAD = VA_W - DIR_W - 2;
    localparam int TPAD = VA_W - TBL_W - 2;

    assign dir_addr_o = base_i + {{DPAD{1'b0}}, dir_idx_i, 2'b00};
    assign tbl_addr_o = {tbl_pn_i, {OFF_W{1'b0}}} + {{TPAD{1'b0}}, tbl_idx_i, 2'b00};
endmodule

// File: rtl/xlat_entry_chk.sv
module xlat_entry_chk
    import xlat_pkg::*;
(
    input  logic [VA_W-1:0] pde_i,
    input  logic [VA_W-1:0] pte_i,
    input  logic            wr_i,
    input  logic            usr_i,
    output logic            prot_flt_o,
    output logic [VA_W-1:0] pde_new_o,
    output logic            pde_chg_o,
    output logic [VA_W-1:0] pte_new_o,
    output logic            pte_chg_o
);
    logic wr_denied;
    logic usr_denied;

    always_comb begin
        wr_denied  = wr_i  && !(pde_i[F_RW] && pte_i[F_RW]);
        usr_denied = usr_i && !(pde_i[F_US] && pte_i[F_US]);
        prot_flt_o = wr_denied || usr_denied;

        pde_new_o          = pde_i;
        pde_new_o[F_ACC]   = 1'b1;
        pte_new_o          = pte_i;
        pte_new_o[F_ACC]   = 1'b1;
        pte_new_o[F_DIRTY] = pte_i[F_DIRTY] | wr_i;

        pde_chg_o = (pde_new_o != pde_i);
        pte_chg_o = (pte_new_o != pte_i);
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     dir_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [31:0]     req_vaddr,
    input  logic            req_write,
    input  logic            req_user,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [31:0]     rsp_paddr,
    output logic [31:0]     rsp_vaddr,
    output logic            rsp_prot,
    output logic            rsp_write,
    output logic            rsp_user,
    output logic            mem_req,
    output logic            mem_we,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata
);
    walk_regs_t r_d, r_q;

    logic [VA_W-1:0] dir_addr, tbl_addr;
    logic            prot_flt, pde_chg, pte_chg;
    logic [VA_W-1:0] pde_new, pte_new;

    xlat_addr_gen u_agen (
        .base_i     (r_q.base),
        .dir_idx_i  (r_q.vaddr[VA_W-1 -: DIR_W]),
        .tbl_idx_i  (r_q.vaddr[OFF_W +: TBL_W]),
        .tbl_pn_i   (r_q.pde[VA_W-1 -: PN_W]),
        .dir_addr_o (dir_addr),
        .tbl_addr_o (tbl_addr)
    );

    xlat_entry_chk u_echk (
        .pde_i      (r_q.pde),
        .pte_i      (mem_rdata),
        .wr_i       (r_q.wr),
        .usr_i      (r_q.usr),
        .prot_flt_o (prot_flt),
        .pde_new_o  (pde_new),
        .pde_chg_o  (pde_chg),
        .pte_new_o  (pte_new),
        .pte_chg_o  (pte_chg)
    );

    always_comb begin
        r_d       = r_q;
        req_ready = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dir_addr;
        mem_wdata = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.vaddr    = req_vaddr;
                    r_d.base     = dir_base;
                    r_d.wr       = req_write;
                    r_d.usr      = req_user;
                    r_d.pde_pend = 1'b0;
                    r_d.pte_pend = 1'b0;
                    r_d.flt_prot = 1'b0;
                    r_d.st       = ST_RD_DIR;
                end
            end
            ST_RD_DIR: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    r_d.pde = mem_rdata;
                    r_d.st  = mem_rdata[F_PRES] ? ST_RD_TBL : ST_FAULT;
                end
            end
            ST_RD_TBL: begin
                mem_req  = 1'b1;
                mem_addr = tbl_addr;
                if (mem_ack) begin
                    if (!mem_rdata[F_PRES]) begin
                        r_d.st = ST_FAULT;
                    end else if (prot_flt) begin
                        r_d.flt_prot = 1'b1;
                        r_d.st       = ST_FAULT;
                    end else begin
                        r_d.pde      = pde_new;
                        r_d.pte      = pte_new;
                        r_d.pde_pend = pde_chg;
                        r_d.pte_pend = pte_chg;
                        r_d.st       = (pde_chg || pte_chg) ? ST_SET_AD : ST_DONE;
                    end
                end
            end
            ST_SET_AD: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (r_q.pde_pend) begin
                    mem_wdata = r_q.pde;
                    if (mem_ack) begin
                        r_d.pde_pend = 1'b0;
                        if (!r_q.pte_pend) r_d.st = ST_DONE;
                    end
                end else begin
                    mem_addr  = tbl_addr;
                    mem_wdata = r_q.pte;
                    if (mem_ack) begin
                        r_d.pte_pend = 1'b0;
                        r_d.st       = ST_DONE;
                    end
                end
            end
            ST_DONE:  r_d.st = ST_IDLE;
            ST_FAULT: r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid = (r_q.st == ST_DONE) || (r_q.st == ST_FAULT);
    assign rsp_fault = (r_q.st == ST_FAULT);
    assign rsp_paddr = {r_q.pte[VA_W-1 -: PN_W], r_q.vaddr[OFF_W-1:0]};
    assign rsp_vaddr = r_q.vaddr;
    assign rsp_prot  = r_q.flt_prot;
    assign rsp_write = r_q.wr;
    assign rsp_user  = r_q.usr;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack
);
    a_r12_cmd_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r11_busy_on_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r11_busy_on_mem: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    a_r9_writeback_sets_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[5]);

    a_r10_fault_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> !$past(mem_we));
endmodule

bind xlat_walker xlat_walker_chk u_walker_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack)
);

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] dir_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid, rsp_fault, rsp_prot, rsp_write, rsp_user;
    logic [31:0] rsp_paddr, rsp_vaddr;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #10 clk = ~clk;

    xlat_walker i_xlat_walker (.*);

    logic [31:0] mem [logic [31:0]];
    int n_chk = 0, n_err = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [31:0] first_rd = '0, second_rd = '0, first_wr = '0;
    bit stall_en = 1'b0;
    bit done = 1'b0;

    function automatic logic [31:0] rdm(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && (!stall_en || $urandom_range(0, 2) != 0)) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    if (wr_cnt == 0) first_wr = mem_addr;
                    wr_cnt++;
                    mem_rdata = '0;
                end else begin
                    mem_rdata = rdm(mem_addr);
                    if (rd_cnt == 0) first_rd = mem_addr;
                    if (rd_cnt == 1) second_rd = mem_addr;
                    rd_cnt++;
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic walk(input logic [31:0] va, input bit wr, input bit usr, input string tag);
        logic [31:0] pa_d, pa_t, pde, pte, npde, npte;
        bit e_flt, e_prot;
        int e_rd, e_wr, t;
        pa_d = dir_base + {20'd0, va[31:22], 2'b00};
        pde = rdm(pa_d);
        pa_t = {pde[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
        pte = rdm(pa_t);
        npde = pde | 32'h20;
        npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
        e_prot = 1'b0;
        if (!pde[0]) begin e_flt = 1; e_rd = 1; e_wr = 0; end
        else if (!pte[0]) begin e_flt = 1; e_rd = 2; e_wr = 0; end
        else if ((wr && !(pde[1] && pte[1])) || (usr && !(pde[2] && pte[2]))) begin
            e_flt = 1; e_prot = 1; e_rd = 2; e_wr = 0;
        end else begin
            e_flt = 0; e_rd = 2; e_wr = int'(npde != pde) + int'(npte != pte);
        end

        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0;
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_valid && t < 400) begin @(negedge clk); t++; end
        chk(rsp_valid, {tag, " R11 response"}, 32'(rsp_valid), 32'd1);
        if (!rsp_valid) return;
        chk(rsp_fault == e_flt, {tag, " R4 fault flag"}, 32'(rsp_fault), 32'(e_flt));
        chk(first_rd == pa_d, {tag, " R2 dir addr"}, first_rd, pa_d);
        chk(rd_cnt == e_rd, {tag, " R5 R6 read count"}, rd_cnt, e_rd);
        chk(wr_cnt == e_wr, {tag, " R10 write count"}, wr_cnt, e_wr);
        if (e_rd == 2) chk(second_rd == pa_t, {tag, " R3 table addr"}, second_rd, pa_t);
        if (e_flt) begin
            chk(rsp_prot == e_prot, {tag, " R7 cause"}, 32'(rsp_prot), 32'(e_prot));
            chk(rsp_vaddr == va, {tag, " R8 vaddr"}, rsp_vaddr, va);
            chk(rsp_write == wr && rsp_user == usr, {tag, " R8 type/mode"},
                {30'd0, rsp_write, rsp_user}, {30'd0, wr, usr});
            chk(rdm(pa_d) == pde, {tag, " R10 dir untouched"}, rdm(pa_d), pde);
        end else begin
            chk(rsp_paddr == {pte[31:12], va[11:0]}, {tag, " R4 paddr"}, rsp_paddr, {pte[31:12], va[11:0]});
            chk(rdm(pa_d) == npde, {tag, " R9 dir flags"}, rdm(pa_d), npde);
            chk(rdm(pa_t) == npte, {tag, " R9 table flags"}, rdm(pa_t), npte);
            if (e_wr == 2) chk(first_wr == pa_d, {tag, " R10 order"}, first_wr, pa_d);
        end
        @(negedge clk);
        chk(!rsp_valid && req_ready, {tag, " R11 pulse end"}, {30'd0, rsp_valid, req_ready}, 32'd1);
    endtask

    function automatic logic [31:0] dslot(input int d);
        return dir_base + 32'(d * 4);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req === 1'b0, "R1 reset",
            {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && mem_req === 1'b0, "R1 after release", {30'd0, req_ready, mem_req}, 32'h2);

        // directed: dirs 5..9 point at tables 0x300000 + d*0x1000
        mem[dslot(5)] = 32'h0030_5006;                 // not present
        walk({10'd5, 10'd3, 12'h123}, 0, 0, "D pde-np R5");
        mem[dslot(6)] = 32'h0030_6007;
        mem[32'h0030_6000 + 4*7] = 32'h0ABC_D006;      // pte not present
        walk({10'd6, 10'd7, 12'h040}, 1, 1, "D pte-np R6");
        mem[dslot(7)] = 32'h0030_7005;                 // rw=0 at dir
        mem[32'h0030_7000 + 4*1] = 32'h0111_1007;
        walk({10'd7, 10'd1, 12'hFFC}, 1, 0, "D wr-prot R7");
        walk({10'd7, 10'd1, 12'hFFC}, 0, 1, "D rd-ok R4");
        mem[32'h0030_7000 + 4*2] = 32'h0222_2063;      // us=0 at table
        walk({10'd7, 10'd2, 12'h008}, 0, 1, "D usr-prot R7");
        mem[32'h0030_7000 + 4*4] = 32'h0444_4006;      // np beats rw
        walk({10'd7, 10'd4, 12'h000}, 1, 0, "D np-first R7");
        mem[dslot(8)] = 32'h0030_8027;
        mem[32'h0030_8000 + 4*9] = 32'h0999_9067;      // A and D set
        walk({10'd8, 10'd9, 12'h555}, 1, 1, "D no-write R10");
        mem[dslot(9)] = 32'h0030_9007;
        mem[32'h0030_9000 + 4*1023] = 32'hFFFF_F007;   // A clear both
        walk({10'd9, 10'd1023, 12'hABC}, 0, 0, "D two-write R9");
        walk({10'd9, 10'd1023, 12'hABC}, 1, 0, "D dirty R9");

        // random
        stall_en = 1'b1;
        for (int i = 0; i < 160; i++) begin
            int d;
            logic [9:0] ti;
            logic [31:0] pde_v, pte_v;
            d = (i % 5 == 4) ? 1023 : $urandom_range(0, 3);
            ti = 10'($urandom_range(0, 1023));
            pde_v = {12'h004, 10'(d), 10'd0} | {23'd0, 9'($urandom)};
            if ($urandom_range(0, 9) != 0) pde_v[0] = 1'b1;
            if ($urandom_range(0, 3) != 0) pde_v[2:1] = 2'b11;
            pte_v = {20'($urandom), 3'd0, 9'($urandom)};
            if ($urandom_range(0, 7) != 0) pte_v[0] = 1'b1;
            if ($urandom_range(0, 3) != 0) pte_v[2:1] = 2'b11;
            mem[dslot(d)] = pde_v;
            mem[{pde_v[31:12], 12'h000} + {20'd0, ti, 2'b00}] = pte_v;
            walk({10'(d), ti, 12'($urandom)}, 1'($urandom), 1'($urandom), "rand R4");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule